// File: doc/BRIEF.md
# Physical memory attribute region matcher

This block keeps a table of sixteen programmable address regions and answers, in the same cycle, which memory-type attribute applies to a physical address. Each region has an address register, and a one-byte setting that selects how the address register is interpreted and which four-bit memory type the region carries. The setting bytes are packed several to a word into configuration registers, so software can write a whole word or change a single region's byte.

The lookup side is purely combinational. It compares the incoming physical address against every enabled region in parallel and picks the lowest-numbered match. When nothing matches, it returns a parameterised default type and raises a miss flag. A read-only capability word reports that programmable attribute support exists.

Register select map: selects 0 to ENTRIES-1 are the address registers, ENTRIES to ENTRIES+CFG_REGS-1 the configuration registers, and ENTRIES+CFG_REGS the capability word. With the default sixteen entries these are 0-15, 16-19 and 20.

Top module: `pma_matcher`

## Requirements
- R1: After reset every address and configuration register reads zero, so all regions are disabled and a lookup of any address reports a miss.
- R2: A word write to select k (k below ENTRIES) stores the data in region k's address register, and reading select k returns it; the register holds the byte address divided by four.
- R3: Region i's setting byte sits at byte (i mod XLEN/8) of configuration register (i div XLEN/8), multiplied by two when XLEN is 64. A word write to a configuration register replaces all of its bytes, and reading it returns the packed bytes.
- R4: A single-byte write to region i's setting changes only that byte. The other bytes of the same configuration register keep their values.
- R5: With XLEN of 64, the odd-numbered configuration registers hold nothing: they read zero and writes to them are ignored.
- R6: The capability select reads as a word with only bit 30 set, and writes to it have no effect.
- R7: Setting bits [1:0] choose the mode: 0 disabled, 1 top-of-range, 2 four-byte, 3 power-of-two. A disabled region never matches, whatever its address register holds.
- R8: In four-byte mode a region matches exactly the aligned four-byte word whose address shifted right by two equals the address register. The two low address bits are ignored.
- R9: In power-of-two mode the trailing ones of the address register give the size. With t trailing ones the region covers 2^(t+3) bytes at the base formed by clearing those bits and the next one; all ones covers everything.
- R10: In top-of-range mode region i matches word addresses from region i-1's address register (zero for region 0) up to but not including its own.
- R11: Setting bits [5:2] are the region's memory type. When several regions match, the lowest-numbered one supplies the type and index.
- R12: When no region matches, the miss flag is high, the type output equals DEFAULT_ATTR and the index output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Word write strobe |
| wr_sel | input | SEL_W | Register select for word writes |
| wr_data | input | XLEN | Word write data |
| ent_we | input | 1 | Single setting-byte write strobe |
| ent_idx | input | IDX_W | Region whose setting byte is written |
| ent_byte | input | 8 | New setting byte |
| rd_sel | input | SEL_W | Register select for reads |
| rd_data | output | XLEN | Read data, combinational |
| pa | input | XLEN+2 | Physical byte address to look up |
| attr | output | 4 | Memory type of the winning region or the default |
| miss | output | 1 | High when no enabled region matches |
| hit_idx | output | IDX_W | Index of the winning region, zero on miss |

## Verification
Each mode is probed at its edges: the first and last word inside a region and the first word outside it on either side. These probes separate an off-by-one bound from a correct one, a trailing-ones mask that is one bit too wide from a correct one, and a top-of-range bound that is wrongly inclusive. Overlapping regions are set up so that the lower index is added last. This shows whether the priority depends on index or on write order, and disabling that region shows whether the mode bits gate the match. Packing is checked by a word write followed by a byte write into the middle of the same word, on both the 32-bit and the 64-bit register width.

// File: rtl/pma_matcher.sv
module pma_matcher #(
  parameter int XLEN = 32,
  parameter int ENTRIES = 16,
  parameter int CFG_REGS = 4,
  parameter int SEL_W = 5,
  parameter int IDX_W = $clog2(ENTRIES),
  parameter logic [3:0] DEFAULT_ATTR = 4'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [XLEN-1:0]   wr_data,
  input  logic              ent_we,
  input  logic [IDX_W-1:0]  ent_idx,
  input  logic [7:0]        ent_byte,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [XLEN-1:0]   rd_data,
  input  logic [XLEN+1:0]   pa,
  output logic [3:0]        attr,
  output logic              miss,
  output logic [IDX_W-1:0]  hit_idx
);
  localparam int BPR = XLEN / 8;
  localparam int CFG_STEP = (XLEN == 64) ? 2 : 1;
  localparam int CFG_BASE = ENTRIES;
  localparam int CAP_SEL = CFG_BASE + CFG_REGS;
  localparam int CAP_BIT = 30;

  function automatic int reg_of(int i);
    return (i / BPR) * CFG_STEP;
  endfunction
  function automatic int byte_of(int i);
    return i % BPR;
  endfunction

  logic [XLEN-1:0] addr_q [ENTRIES];
  logic [7:0]      cfg_q  [ENTRIES];
  logic [XLEN-1:0] lo     [ENTRIES];
  logic [ENTRIES-1:0] hit_v;
  wire  [XLEN-1:0] pw = pa[XLEN+1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        addr_q[i] <= '0;
        cfg_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_en && wr_sel == SEL_W'(i)) addr_q[i] <= wr_data;
        if (wr_en && wr_sel == SEL_W'(CFG_BASE + reg_of(i)))
          cfg_q[i] <= wr_data[byte_of(i)*8 +: 8];
        if (ent_we && ent_idx == IDX_W'(i)) cfg_q[i] <= ent_byte;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rd_sel == SEL_W'(i)) rd_data = addr_q[i];
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (rd_sel == SEL_W'(CFG_BASE + reg_of(i)))
        rd_data[byte_of(i)*8 +: 8] = cfg_q[i];
    end
    if (rd_sel == SEL_W'(CAP_SEL)) rd_data[CAP_BIT] = 1'b1;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    if (g == 0) begin : g_first
      assign lo[g] = '0;
    end else begin : g_rest
      assign lo[g] = addr_q[g-1];
    end
    wire [XLEN-1:0] care = ~(addr_q[g] ^ (addr_q[g] + 1'b1));
    always_comb begin
      case (cfg_q[g][1:0])
        2'd1:    hit_v[g] = (pw >= lo[g]) && (pw < addr_q[g]);
        2'd2:    hit_v[g] = (pw == addr_q[g]);
        2'd3:    hit_v[g] = ((pw ^ addr_q[g]) & care) == '0;
        default: hit_v[g] = 1'b0;
      endcase
    end

    // R4
    ent_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_we && ent_idx != IDX_W'(g) && !wr_en) |=> $stable(cfg_q[g]));
    // R2
    addr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_W'(g)) |=> addr_q[g] == $past(wr_data));
  end

  always_comb begin
    attr = DEFAULT_ATTR;
    miss = 1'b1;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        attr = cfg_q[i][5:2];
        miss = 1'b0;
        hit_idx = IDX_W'(i);
      end
    end
  end

  // R1
  reset_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> miss);
  // R12
  miss_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (attr == DEFAULT_ATTR && hit_idx == '0 && hit_v == '0));
  // R11
  lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !miss |-> (hit_v[hit_idx] &&
               (hit_v & ((ENTRIES'(1) << hit_idx) - 1'b1)) == '0));
  // R6
  cap_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_W'(CAP_SEL)) |-> rd_data == (XLEN'(1) << CAP_BIT));
endmodule

// File: tb/pma_matcher_test.sv
`timescale 1ns/1ps
module pma_matcher_test;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic wr_en = 0, ent_we = 0;
  logic [4:0] wr_sel = 0, rd_sel = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [3:0] ent_idx = 0, hit_idx;
  logic [7:0] ent_byte = 0;
  logic [33:0] pa = 0;
  logic [3:0] attr;
  logic miss;

  pma_matcher #(.DEFAULT_ATTR(4'h5)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ent_we(ent_we), .ent_idx(ent_idx), .ent_byte(ent_byte), .rd_sel(rd_sel),
    .rd_data(rd_data), .pa(pa), .attr(attr), .miss(miss), .hit_idx(hit_idx));

  logic w6_en = 0, b6_we = 0;
  logic [4:0] w6_sel = 0, r6_sel = 0;
  logic [63:0] w6_data = 0, r6_data;
  logic [3:0] b6_idx = 0, h6_idx, a6;
  logic [7:0] b6_byte = 0;
  logic m6;

  pma_matcher #(.XLEN(64)) uut64 (
    .clk(clk), .rst_n(rst_n), .wr_en(w6_en), .wr_sel(w6_sel), .wr_data(w6_data),
    .ent_we(b6_we), .ent_idx(b6_idx), .ent_byte(b6_byte), .rd_sel(r6_sel),
    .rd_data(r6_data), .pa(66'd0), .attr(a6), .miss(m6), .hit_idx(h6_idx));

  typedef struct { int kind; logic [63:0] exp; string req; } item_t;
  item_t q[$];
  int nchk = 0, nfail = 0;
  bit done = 0;

  always @(negedge clk) begin : monitor
    item_t it;
    logic [63:0] act;
    if (q.size() > 0) begin
      it = q.pop_front();
      case (it.kind)
        0: act = 64'(rd_data);
        1: act = 64'({miss, attr, hit_idx});
        default: act = r6_data;
      endcase
      nchk++;
      if (act !== it.exp) begin
        nfail++;
        $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
      end
    end
  end

  task automatic tick; @(posedge clk); #1; endtask
  task automatic wr(input logic [4:0] s, input logic [31:0] d);
    tick; wr_en = 1; wr_sel = s; wr_data = d; tick; wr_en = 0;
  endtask
  task automatic bw(input logic [3:0] i, input logic [7:0] b);
    tick; ent_we = 1; ent_idx = i; ent_byte = b; tick; ent_we = 0;
  endtask
  task automatic rd(input logic [4:0] s, input logic [31:0] e, input string r);
    tick; rd_sel = s; q.push_back('{0, 64'(e), r});
  endtask
  task automatic look(input logic [33:0] a, input logic m, input logic [3:0] at,
                      input logic [3:0] ix, input string r);
    tick; pa = a; q.push_back('{1, 64'({m, at, ix}), r});
  endtask
  task automatic rd6(input logic [4:0] s, input logic [63:0] e, input string r);
    tick; r6_sel = s; q.push_back('{2, e, r});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick;
    rst_n = 1;
    // R1 reset state
    rd(0, 0, "R1 addr0");
    rd(16, 0, "R1 cfg0");
    look(34'h0, 1, 4'h5, 0, "R1 lookup");
    // R6 capability word, write ignored
    rd(20, 32'h4000_0000, "R6 cap");
    wr(20, 32'hFFFF_FFFF);
    rd(20, 32'h4000_0000, "R6 cap after write");
    // R2 address register
    wr(3, 32'h1234_5678);
    rd(3, 32'h1234_5678, "R2 addr3");
    // R3 / R4 packing
    wr(17, 32'h1122_3344);
    rd(17, 32'h1122_3344, "R3 cfg1 word");
    bw(6, 8'h2D);
    rd(17, 32'h112D_3344, "R4 byte write entry6");
    wr(17, 0);
    rd(17, 0, "R3 cfg1 cleared");
    // R8 four-byte region, entry 2, type 3
    wr(2, 32'h400); bw(2, 8'h0E);
    look(34'h1000, 0, 4'd3, 2, "R8 na4 hit");
    look(34'h1003, 0, 4'd3, 2, "R8 na4 low bits");
    look(34'h1004, 1, 4'h5, 0, "R8 na4 next word");
    look(34'h0FFC, 1, 4'h5, 0, "R8 na4 prev word");
    // R9 power-of-two 4 KiB at 0x8000, entry 5, type 11
    wr(5, 32'h21FF); bw(5, 8'h2F);
    look(34'h8000, 0, 4'd11, 5, "R9 napot first");
    look(34'h8FFC, 0, 4'd11, 5, "R9 napot last");
    look(34'h9000, 1, 4'h5, 0, "R9 napot above");
    look(34'h7FFC, 1, 4'h5, 0, "R9 napot below");
    // R10 top-of-range, entry 9 from entry 8 address, type 7
    wr(8, 32'h8000); wr(9, 32'hC000); bw(9, 8'h1D);
    look(34'h20000, 0, 4'd7, 9, "R10 tor low bound");
    look(34'h2FFFC, 0, 4'd7, 9, "R10 tor last");
    look(34'h30000, 1, 4'h5, 0, "R10 tor top excluded");
    look(34'h1FFFC, 1, 4'h5, 0, "R10 tor below");
    // R10 entry 0 starts at zero, type 1
    wr(0, 32'h10); bw(0, 8'h05);
    look(34'h0, 0, 4'd1, 0, "R10 tor0 zero");
    look(34'h3C, 0, 4'd1, 0, "R10 tor0 last");
    look(34'h40, 1, 4'h5, 0, "R10 tor0 top");
    // R11 priority
    wr(12, 32'h2004); bw(12, 8'h26);
    look(34'h8010, 0, 4'd11, 5, "R11 entry5 beats 12");
    wr(1, 32'h2004); bw(1, 8'h12);
    look(34'h8010, 0, 4'd4, 1, "R11 entry1 beats 5");
    // R7 disabled region ignored
    bw(1, 8'h10);
    look(34'h8010, 0, 4'd11, 5, "R7 off entry1");
    rd(16, 32'h000E_1005, "R3 cfg0 packed");
    // R12 miss far away
    look(34'h3_0000_0000, 1, 4'h5, 0, "R12 miss default");
    // R5 64-bit packing
    tick; b6_we = 1; b6_idx = 9; b6_byte = 8'hAB; tick; b6_we = 0;
    rd6(18, 64'hAB00, "R5 cfg2 entry9 byte1");
    tick; w6_en = 1; w6_sel = 17; w6_data = '1; tick; w6_en = 0;
    rd6(17, 64'h0, "R5 odd cfg reads zero");
    rd6(16, 64'h0, "R5 even cfg untouched");
    repeat (3) tick;
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule